// File: doc/BRIEF.md
# DAC Power-Up Sequencer

This block is the control state machine that walks a stereo audio DAC from power-on reset to normal playback and back again. It watches a power-good level, flags that say whether the master clock and frame clock are running, and flags from a clock-ratio detector. It uses these to step through a power-down state, an initialise state, a ratio-detect state, a timed power-up sequence, normal operation and a mute state. Its outputs drive the analog enables directly: output pulldowns, the charge pump, the reference (and its short to ground), the interpolation filters and modulator, the output amplifiers, and mute.

The power-up sequence switches on one enable per step. Each step lasts a programmable number of pulses on a timer tick input, and mute is held until the last step ends. The serial-clock mode (external clock or internally derived) is captured when the sequence finishes, and de-emphasis can only be selected in the internal mode. A separate counter watches the incoming sample stream. It raises a safe-to-stop flag after a long run of consecutive all-zero samples.

Top module: `dac_pwr_seq`

## Requirements
- R1: While rst_n is low, and from the clock edge after pwr_good is seen low, the outputs are pulldown_en=1, ref_short=1, cp_en=0, filt_en=0, ref_en=0, amp_en=0, mute=1.
- R2: After pwr_good rises, the block passes through power-down and stays there with cp_en=0 for as long as mclk_ok is low.
- R3: With mclk_ok high, power-down moves to initialise on the next edge. Initialise sets cp_en=1 and keeps pulldown_en=1 and ref_short=1.
- R4: Initialise moves to ratio detect only while lrck_ok is high. Ratio detect falls back to initialise if lrck_ok drops. ratio_ok is ignored until ratio detect is reached.
- R5: ratio_ok in ratio detect starts power-up with four steps in a fixed order. Step 0 sets filt_en. Step 1 adds ref_en and clears ref_short. Step 2 clears pulldown_en. Step 3 sets amp_en. Each step ends on its step_ticks-th tick pulse.
- R6: mute is 1 in every state except normal. It clears on the edge where the last power-up step ends.
- R7: ratio_chg in normal moves to a mute state on the next edge with all enables held. That state returns to normal once ratio_ok=1 and ratio_chg=0.
- R8: ext_sclk is captured into sclk_ext_mode when power-up completes and is held afterwards. deemph_on = normal state AND sclk_ext_mode=0 AND dem_sel=1.
- R9: With pwr_good high, mclk_ok low moves any state after reset to power-down on the next edge. This takes priority over every other transition, including a ratio change in the same cycle.
- R10: zero_safe is 1 once ZERO_RUN consecutive valid samples (sample_vld=1) have been all-zero. Cycles with sample_vld=0 do not break the run. A valid non-zero sample clears the run and the flag on the next edge.
- R11: A step_ticks value of 0 acts as 1.
- R12: pwr_good low clears the zero-run count and zero_safe on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply good; low forces the reset state |
| mclk_ok | input | 1 | Master clock detected |
| lrck_ok | input | 1 | Frame clock detected |
| ratio_ok | input | 1 | Clock ratio detector reports a valid ratio |
| ratio_chg | input | 1 | Clock ratio detector reports a ratio change |
| ext_sclk | input | 1 | External serial clock detected (1) or absent (0) |
| dem_sel | input | 1 | De-emphasis request level |
| tick | input | 1 | Timer tick pulse |
| step_ticks | input | TICK_W | Tick pulses per power-up step |
| sample_vld | input | 1 | Sample strobe |
| sample | input | DATA_W | Sample value |
| pulldown_en | output | 1 | Analog output pulldowns on |
| ref_short | output | 1 | Reference tied to ground |
| cp_en | output | 1 | Charge pump on |
| ref_en | output | 1 | Reference on |
| filt_en | output | 1 | Filters and modulator on |
| amp_en | output | 1 | Output amplifiers on |
| mute | output | 1 | Output muted |
| deemph_on | output | 1 | De-emphasis filter active |
| sclk_ext_mode | output | 1 | Captured serial-clock mode, 1 = external |
| zero_safe | output | 1 | Zero run reached, safe to stop |

## Verification
The bench is aimed at the cycles where two transitions meet. A ratio-change pulse and loss of the master clock are driven in the same cycle during normal operation. Power-good is dropped while a long zero run is in progress. The expected outcome is that clock loss wins, so the charge pump turns off with no pass through the mute state, and that the zero counter clears together with the state reset. A behavioural model in the bench follows state, step, tick count and zero run as plain integers, and it is compared with every output on every clock. This shows any wrong priority in the same cycle it occurs.

// File: rtl/dac_pwr_pkg.sv
package dac_pwr_pkg;
  typedef enum logic [2:0] {
    S_RESET, S_PDOWN, S_INIT, S_RDET, S_PUP, S_NORM, S_MUTE
  } seq_state_e;

  // Power-up step order: the decoder relies on these indices
  localparam int unsigned NUM_STEPS = 4;
  localparam int unsigned STEP_REF  = 1;  // reference on, short removed
  localparam int unsigned STEP_OPEN = 2;  // pulldowns removed
  localparam int unsigned STEP_AMP  = 3;  // amplifiers on
endpackage

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [TICK_W-1:0] limit,
  output logic              done
);
  logic [TICK_W-1:0] cnt_q, cnt_d, lim_eff;
  logic              cnt_en;

  assign lim_eff = (limit == '0) ? TICK_W'(1) : limit;
  assign done    = run && tick && (cnt_q >= lim_eff - TICK_W'(1));
  assign cnt_en  = !run || tick;

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (done) cnt_d = '0;
    else           cnt_d = cnt_q + TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seq_zero_run.sv
module seq_zero_run #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RUN_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  output logic              flag
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr || vld;

  always_comb begin
    if (clr || (data != '0))  cnt_d = '0;
    else if (cnt_q == RUN_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign flag = (cnt_q == RUN_MAX);
endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
  import dac_pwr_pkg::*;
#(
  parameter int unsigned STEP_W = 2
) (
  input  seq_state_e        state,
  input  logic [STEP_W-1:0] step,
  input  logic              ext_mode,
  input  logic              dem_sel,
  output logic              pulldown_en,
  output logic              ref_short,
  output logic              cp_en,
  output logic              ref_en,
  output logic              filt_en,
  output logic              amp_en,
  output logic              mute,
  output logic              deemph_on
);
  logic early, pup, running;
  assign early   = (state == S_RESET) || (state == S_PDOWN) ||
                   (state == S_INIT)  || (state == S_RDET);
  assign pup     = (state == S_PUP);
  assign running = (state == S_NORM) || (state == S_MUTE);

  always_comb begin
    cp_en       = !((state == S_RESET) || (state == S_PDOWN));
    filt_en     = pup || running;
    ref_en      = running || (pup && (step >= STEP_W'(STEP_REF)));
    ref_short   = !ref_en;
    pulldown_en = early || (pup && (step < STEP_W'(STEP_OPEN)));
    amp_en      = running || (pup && (step == STEP_W'(STEP_AMP)));
    mute        = (state != S_NORM);
    deemph_on   = (state == S_NORM) && !ext_mode && dem_sel;
  end
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dac_pwr_pkg::*;
#(
  parameter int unsigned TICK_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ZERO_RUN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              mclk_ok,
  input  logic              lrck_ok,
  input  logic              ratio_ok,
  input  logic              ratio_chg,
  input  logic              ext_sclk,
  input  logic              dem_sel,
  input  logic              tick,
  input  logic [TICK_W-1:0] step_ticks,
  input  logic              sample_vld,
  input  logic [DATA_W-1:0] sample,
  output logic              pulldown_en,
  output logic              ref_short,
  output logic              cp_en,
  output logic              ref_en,
  output logic              filt_en,
  output logic              amp_en,
  output logic              mute,
  output logic              deemph_on,
  output logic              sclk_ext_mode,
  output logic              zero_safe
);
  localparam int unsigned STEP_W = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              ext_q, ext_d;
  logic              step_done, last_step;

  seq_step_timer #(.TICK_W(TICK_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == S_PUP),
    .tick  (tick),
    .limit (step_ticks),
    .done  (step_done)
  );

  assign last_step = (step_q == LAST_STEP);

  // next state: power-good first, then clock loss, then per state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    ext_d   = ext_q;
    if (!pwr_good) begin
      state_d = S_RESET;
    end else if (state_q == S_RESET) begin
      state_d = S_PDOWN;
    end else if (!mclk_ok) begin
      state_d = S_PDOWN;
    end else begin
      case (state_q)
        S_PDOWN: state_d = S_INIT;
        S_INIT:  if (lrck_ok) state_d = S_RDET;
        S_RDET: begin
          if (!lrck_ok)     state_d = S_INIT;
          else if (ratio_ok) state_d = S_PUP;
        end
        S_PUP: begin
          if (step_done) begin
            if (last_step) begin
              state_d = S_NORM;
              ext_d   = ext_sclk;
            end else begin
              step_d = step_q + STEP_W'(1);
            end
          end
        end
        S_NORM: if (ratio_chg) state_d = S_MUTE;
        S_MUTE: if (ratio_ok && !ratio_chg) state_d = S_NORM;
        default: state_d = S_RESET;
      endcase
    end
    if (state_d != S_PUP) step_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RESET;
      step_q  <= '0;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      ext_q   <= ext_d;
    end
  end

  seq_out_decode #(.STEP_W(STEP_W)) u_dec (
    .state       (state_q),
    .step        (step_q),
    .ext_mode    (ext_q),
    .dem_sel     (dem_sel),
    .pulldown_en (pulldown_en),
    .ref_short   (ref_short),
    .cp_en       (cp_en),
    .ref_en      (ref_en),
    .filt_en     (filt_en),
    .amp_en      (amp_en),
    .mute        (mute),
    .deemph_on   (deemph_on)
  );

  assign sclk_ext_mode = ext_q;

  seq_zero_run #(.DATA_W(DATA_W), .RUN_LEN(ZERO_RUN)) u_zero (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!pwr_good),
    .vld   (sample_vld),
    .data  (sample),
    .flag  (zero_safe)
  );
endmodule

// File: rtl/dac_pwr_seq_chk.sv
module dac_pwr_seq_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              mclk_ok,
  input logic              ratio_chg,
  input logic              sample_vld,
  input logic [DATA_W-1:0] sample,
  input logic              pulldown_en,
  input logic              ref_short,
  input logic              cp_en,
  input logic              ref_en,
  input logic              filt_en,
  input logic              amp_en,
  input logic              mute,
  input logic              deemph_on,
  input logic              sclk_ext_mode,
  input logic              zero_safe
);
  // R1
  pg_low_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> pulldown_en && ref_short && !cp_en && mute);

  // R9
  mclk_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good && !mclk_ok |=> !cp_en && !filt_en && !amp_en && mute);

  // R5
  amp_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_en) |-> $past(!pulldown_en && ref_en));

  // R5
  ref_after_filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> filt_en && $past(filt_en));

  // R6
  unmute_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> amp_en && !pulldown_en);

  // R7
  ratio_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good && mclk_ok && !mute && ratio_chg |=> mute && amp_en);

  // R8
  deemph_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deemph_on |-> !sclk_ext_mode && !mute);

  // R10
  zero_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good && sample_vld && (sample != '0) |=> !zero_safe);
endmodule

bind dac_pwr_seq dac_pwr_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dac_pwr_seq_test.sv
module dac_pwr_seq_test;
  localparam int TICK_W = 8, DATA_W = 16, ZERO_RUN = 8192, TDIV = 3;
  localparam int ST_RST = 0, ST_PD = 1, ST_INIT = 2, ST_RDET = 3,
                 ST_PUP = 4, ST_NORM = 5, ST_MUTE = 6;

  logic clk = 1'b0;
  logic rst_n, pwr_good, mclk_ok, lrck_ok, ratio_ok, ratio_chg;
  logic ext_sclk, dem_sel, tick, sample_vld;
  logic [TICK_W-1:0] step_ticks;
  logic [DATA_W-1:0] sample;
  logic pulldown_en, ref_short, cp_en, ref_en, filt_en, amp_en;
  logic mute, deemph_on, sclk_ext_mode, zero_safe;

  int checks = 0, failures = 0, ncyc = 0, tick_ctr = 0;
  bit tick_on = 1'b1, done_flag = 1'b0;

  always #4 clk = ~clk;

  dac_pwr_seq #(.TICK_W(TICK_W), .DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) uut (.*);

  // behavioural reference model
  int m_st, m_step, m_cnt, m_ext, m_zc;
  int lim, nst, nstep, ncnt, next_e, nzc;
  bit done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = ST_RST; m_step = 0; m_cnt = 0; m_ext = 0; m_zc = 0;
    end else begin
      lim  = (step_ticks == 0) ? 1 : int'(step_ticks);
      done = (m_st == ST_PUP) && tick && (m_cnt + 1 >= lim);
      nst = m_st; next_e = m_ext;
      if (!pwr_good) nst = ST_RST;
      else if (m_st == ST_RST) nst = ST_PD;
      else if (!mclk_ok) nst = ST_PD;
      else if (m_st == ST_PD) nst = ST_INIT;
      else if (m_st == ST_INIT) begin if (lrck_ok) nst = ST_RDET; end
      else if (m_st == ST_RDET) begin
        if (!lrck_ok) nst = ST_INIT; else if (ratio_ok) nst = ST_PUP;
      end else if (m_st == ST_PUP) begin
        if (done && m_step == 3) begin nst = ST_NORM; next_e = ext_sclk; end
      end else if (m_st == ST_NORM) begin if (ratio_chg) nst = ST_MUTE; end
      else if (m_st == ST_MUTE) begin if (ratio_ok && !ratio_chg) nst = ST_NORM; end
      nstep = (nst == ST_PUP && m_st == ST_PUP) ? (done ? m_step + 1 : m_step) : 0;
      if (m_st != ST_PUP) ncnt = 0;
      else if (tick) ncnt = done ? 0 : m_cnt + 1;
      else ncnt = m_cnt;
      if (!pwr_good) nzc = 0;
      else if (sample_vld) nzc = (sample == 0) ? ((m_zc < ZERO_RUN) ? m_zc + 1 : m_zc) : 0;
      else nzc = m_zc;
      m_st = nst; m_step = nstep; m_cnt = ncnt; m_ext = next_e; m_zc = nzc;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the model on every falling edge
  bit early, e_ref;
  always @(negedge clk) begin
    ncyc++;
    early = (m_st <= ST_RDET);
    e_ref = (m_st == ST_NORM) || (m_st == ST_MUTE) || (m_st == ST_PUP && m_step >= 1);
    check("R1 pulldown_en", pulldown_en, early || (m_st == ST_PUP && m_step < 2));
    check("R1 ref_short", ref_short, !e_ref);
    check("R3 cp_en", cp_en, m_st >= ST_INIT);
    check("R5 filt_en", filt_en, m_st >= ST_PUP);
    check("R5 ref_en", ref_en, e_ref);
    check("R5 amp_en", amp_en, m_st >= ST_NORM || (m_st == ST_PUP && m_step == 3));
    check("R6 mute", mute, m_st != ST_NORM);
    check("R8 deemph_on", deemph_on, m_st == ST_NORM && m_ext == 0 && dem_sel);
    check("R8 sclk_ext_mode", sclk_ext_mode, m_ext);
    check("R10 zero_safe", zero_safe, m_zc == ZERO_RUN);
    if (ncyc > 100000 && !done_flag) begin
      done_flag = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick_ctr++;
      tick = tick_on && (tick_ctr % TDIV == 0);
    end
  endtask

  task automatic wait_unmute(output int cnt);
    cnt = 0;
    while (mute && cnt < 500) begin cyc(); cnt++; end
  endtask

  int n;
  initial begin
    rst_n = 0; pwr_good = 0; mclk_ok = 0; lrck_ok = 0; ratio_ok = 0;
    ratio_chg = 0; ext_sclk = 0; dem_sel = 0; tick = 0; step_ticks = 2;
    sample_vld = 0; sample = '0;
    cyc(3);
    check("R1 reset pulldown", pulldown_en, 1);
    check("R1 reset ref_short", ref_short, 1);
    check("R1 reset mute", mute, 1);
    check("R1 reset amp", amp_en, 0);
    rst_n = 1; cyc(3);
    check("R1 pg low cp", cp_en, 0);
    pwr_good = 1; cyc(5);
    check("R2 no mclk cp", cp_en, 0);
    mclk_ok = 1; cyc(2);
    check("R3 init cp", cp_en, 1);
    check("R3 init pulldown", pulldown_en, 1);
    ratio_ok = 1; cyc(4);
    check("R4 ratio ignored w/o lrck", filt_en, 0);
    lrck_ok = 1; dem_sel = 1; cyc(2);
    check("R5 step0 filt", filt_en, 1);
    check("R5 step0 ref", ref_en, 0);
    check("R6 muted in power-up", mute, 1);
    wait_unmute(n);
    check("R5 sequence length", int'(n <= 4 * 2 * TDIV + 2), 1);
    check("R8 deemph internal", deemph_on, 1);
    dem_sel = 0; cyc();
    check("R8 deemph deselected", deemph_on, 0);
    dem_sel = 1;
    ratio_chg = 1; ratio_ok = 0; cyc();
    check("R7 mute on ratio change", mute, 1);
    check("R7 amp held", amp_en, 1);
    ratio_chg = 0; cyc(3);
    check("R7 waits for ratio", mute, 1);
    ratio_ok = 1; cyc();
    check("R7 back to normal", mute, 0);
    // zero run
    sample_vld = 1; sample = '0; cyc(ZERO_RUN - 1);
    check("R10 one short", zero_safe, 0);
    cyc();
    check("R10 run reached", zero_safe, 1);
    sample_vld = 0; sample = 16'h0005; cyc(5);
    check("R10 idle keeps flag", zero_safe, 1);
    sample_vld = 1; cyc();
    check("R10 nonzero clears", zero_safe, 0);
    sample = '0; cyc(ZERO_RUN);
    check("R10 run again", zero_safe, 1);
    pwr_good = 0; cyc();
    check("R12 pg low clears zero", zero_safe, 0);
    check("R1 pg low from normal", pulldown_en, 1);
    sample_vld = 0;
    // second bring-up: external clock, zero step count
    step_ticks = 0; ext_sclk = 1; pwr_good = 1;
    wait_unmute(n);
    check("R11 zero step_ticks", int'(n <= 4 * TDIV + 6), 1);
    check("R8 ext mode captured", sclk_ext_mode, 1);
    check("R8 no deemph external", deemph_on, 0);
    ext_sclk = 0; cyc();
    check("R8 mode held", sclk_ext_mode, 1);
    // ratio change and clock loss together
    ratio_chg = 1; mclk_ok = 0; cyc();
    check("R9 clock loss wins cp", cp_en, 0);
    check("R9 clock loss amp", amp_en, 0);
    ratio_chg = 0; mclk_ok = 1; lrck_ok = 1; ratio_ok = 0; cyc(3);
    lrck_ok = 0; ratio_ok = 1; cyc(3);
    check("R4 lrck lost in detect", filt_en, 0);
    lrck_ok = 1; cyc(2);
    check("R4 resume detect", filt_en, 1);
    mclk_ok = 0; cyc();
    check("R9 loss during power-up", filt_en, 0);
    cyc(4);
    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule